// File: doc/BRIEF.md
# Priority Address-Window Chip-Select Decoder

This block turns a processor address into one registered select line for a memory or I/O target. There are eight ROM blocks, one SRAM, one I/O space and one peripheral I/O space. Each target is reached through an address window: a base address, a power-of-two size and an enable bit. Software loads these through a small write port. ROM block 7 has two windows of its own, so it can appear in two separate parts of the address map. A typical use is a boot vector placed high in memory, with the rest of the block placed elsewhere.

The SRAM, I/O and peripheral I/O windows may lie on top of ROM windows. Where they do, they take the address and the ROM select stays low. This lets small RAM or I/O spaces fill gaps in a ROM region. The block also checks the loaded configuration against the map rules. These rules cover overlapping ROM blocks, overlapping RAM/I/O spaces, ROM windows larger than a physical block, and a reserved density code. While any rule is broken, every select is held low.

A ROM organisation register holds a density code and a word-width bit. Together they set the physical size of each ROM block. The decode has one registered stage: the address and strobe seen at a rising clock edge decide the select lines that follow that edge.

Top module: `csdec_map`

## Requirements
- R1: While reset is applied, and right after it, every select and `config_error` are low and every window is disabled. With a disabled window, no address produces a select.
- R2: An enabled window of size code S matches an address when the address bits from bit S upward equal the same bits of its base. Base bits below S are ignored, and S at or above the address width matches every address. A disabled window never matches.
- R3: Selects are registered. The address and `cyc_strobe` sampled at a rising edge set the selects that hold after that edge. If the strobe is low at that edge, every select is low.
- R4: ROM block 7 is selected when the address falls in window A (write index 7) or in window B (write index 8).
- R5: On overlap, priority is SRAM, then I/O, then peripheral I/O, then ROM. ROM blocks rank by lower block number. Whenever a RAM or I/O select is high, every ROM select is low.
- R6: At most one of the eleven select outputs is high in any cycle.
- R7: `config_error` is high when enabled windows of two different ROM blocks overlap. The two windows of block 7 may overlap each other freely.
- R8: `config_error` is high when any two of the enabled SRAM, I/O and peripheral I/O windows overlap.
- R9: `config_error` is high when an enabled ROM window has a size code above the block size code. The block size code is BLK_LOG_MIN (default 12) + density − wide. It is also high when the density code is the reserved value 3.
- R10: While `config_error` is high at a rising edge, every select after that edge is low.
- R11: Write port: when `cfg_we` is high at a rising edge, `cfg_idx` picks the target. Index 0–6 are ROM blocks 0–6, 7 is block 7 window A and 8 is block 7 window B. Index 9 is SRAM, 10 is I/O and 11 is peripheral I/O; each of these stores `cfg_base`, `cfg_size` and `cfg_en`. Index 15 loads the organisation register, with density from `cfg_base[1:0]` and wide from `cfg_base[2]`. Index 12–14 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_strobe | input | 1 | Bus cycle active |
| addr | input | ADDR_W | Processor address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration target index |
| cfg_base | input | ADDR_W | Window base, or organisation bits at index 15 |
| cfg_size | input | SZ_W | Window size as log2 of bytes |
| cfg_en | input | 1 | Window enable |
| rom_sel | output | 8 | ROM block selects |
| ram_sel | output | 1 | SRAM select |
| io_sel | output | 1 | I/O select |
| pio_sel | output | 1 | Peripheral I/O select |
| config_error | output | 1 | Map rule violation |

## Verification
Two legal maps are swept across the whole 16-bit space. The sweep tests both the first and the last byte of every 16-byte granule, so each window edge is seen from both sides. The first map places SRAM and I/O over ROM blocks 0 and 7 and puts block 7's second window at the top of memory. This tells priority suppression apart from plain window matching. The second map enlarges one ROM block under a larger density, which shows that the size limit follows the organisation register. Gaps in the strobe tell registered gating apart from decoding. Single-rule violations are then applied and undone one at a time, which separates each error source. Writes to unused indices, unaligned base bits and disabled windows show what the decoder ignores.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int NUM_ROM_BLK = 8;
  localparam int WIN_B7_A    = 7;
  localparam int WIN_B7_B    = 8;
  localparam int NUM_ROM_WIN = 9;
  localparam int WIN_RAM     = 9;
  localparam int WIN_IO      = 10;
  localparam int WIN_PIO     = 11;
  localparam int NUM_WIN     = 12;
  localparam int CFG_IDX_W   = 4;
  localparam int IDX_ORG     = 15;

  typedef enum logic [1:0] {
    DENS_SMALL = 2'd0,
    DENS_MID   = 2'd1,
    DENS_LARGE = 2'd2,
    DENS_RSVD  = 2'd3
  } rom_dens_e;

  // ROM block served by a ROM window index
  function automatic int win_block(input int w);
    return (w == WIN_B7_B) ? WIN_B7_A : w;
  endfunction

  // Window pairs that the map rules forbid from overlapping
  function automatic bit pair_checked(input int i, input int j);
    if (i < NUM_ROM_WIN && j < NUM_ROM_WIN) return win_block(i) != win_block(j);
    return (i >= WIN_RAM) && (j >= WIN_RAM);
  endfunction

endpackage

// File: rtl/csdec_cfg_regs.sv
module csdec_cfg_regs
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic [SZ_W-1:0]      cfg_size,
  input  logic                 cfg_en,
  output logic [ADDR_W-1:0]    win_base [NUM_WIN],
  output logic [SZ_W-1:0]      win_size [NUM_WIN],
  output logic                 win_en   [NUM_WIN],
  output rom_dens_e            rom_dens,
  output logic                 rom_wide
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              ld;
    logic [ADDR_W-1:0] base_d, base_q;
    logic [SZ_W-1:0]   size_d, size_q;
    logic              en_d, en_q;

    always_comb begin
      ld     = cfg_we && (cfg_idx == CFG_IDX_W'(w));
      base_d = cfg_base;
      size_d = cfg_size;
      en_d   = cfg_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        size_q <= '0;
        en_q   <= 1'b0;
      end else if (ld) begin
        base_q <= base_d;
        size_q <= size_d;
        en_q   <= en_d;
      end
    end

    assign win_base[w] = base_q;
    assign win_size[w] = size_q;
    assign win_en[w]   = en_q;
  end

  logic      org_ld;
  rom_dens_e dens_d, dens_q;
  logic      wide_d, wide_q;

  always_comb begin
    org_ld = cfg_we && (cfg_idx == CFG_IDX_W'(IDX_ORG));
    dens_d = rom_dens_e'(cfg_base[1:0]);
    wide_d = cfg_base[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dens_q <= DENS_SMALL;
      wide_q <= 1'b0;
    end else if (org_ld) begin
      dens_q <= dens_d;
      wide_q <= wide_d;
    end
  end

  assign rom_dens = dens_q;
  assign rom_wide = wide_q;

endmodule

// File: rtl/csdec_window_match.sv
module csdec_window_match
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] win_base [NUM_WIN],
  input  logic [SZ_W-1:0]   win_size [NUM_WIN],
  input  logic              win_en   [NUM_WIN],
  output logic [NUM_WIN-1:0] hit
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] keep;

    // bits at or above the size code take part in the compare
    always_comb begin
      for (int b = 0; b < ADDR_W; b++) begin
        keep[b] = (SZ_W'(b) >= win_size[w]);
      end
    end

    assign hit[w] = win_en[w] && (((addr ^ win_base[w]) & keep) == '0);
  end

endmodule

// File: rtl/csdec_rule_check.sv
module csdec_rule_check
  import csdec_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SZ_W        = 5,
  parameter int BLK_LOG_MIN = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] win_base [NUM_WIN],
  input  logic [SZ_W-1:0]   win_size [NUM_WIN],
  input  logic              win_en   [NUM_WIN],
  input  rom_dens_e         rom_dens,
  input  logic              rom_wide,
  output logic              cfg_err
);

  localparam int NUM_PAIR = NUM_WIN * NUM_WIN;

  function automatic logic [ADDR_W-1:0] upper_mask(input logic [SZ_W-1:0] s);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) m[b] = (SZ_W'(b) >= s);
    return m;
  endfunction

  // pairwise overlap of aligned power-of-two windows
  logic [NUM_PAIR-1:0] pair_bad;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_i
    for (genvar j = 0; j < NUM_WIN; j++) begin : g_j
      if (j > i && pair_checked(i, j)) begin : g_chk
        logic [SZ_W-1:0] big;
        assign big = (win_size[i] > win_size[j]) ? win_size[i] : win_size[j];
        assign pair_bad[i*NUM_WIN+j] = win_en[i] && win_en[j] &&
               (((win_base[i] ^ win_base[j]) & upper_mask(big)) == '0);
      end else begin : g_skip
        assign pair_bad[i*NUM_WIN+j] = 1'b0;
      end
    end
  end

  // ROM window larger than one physical block
  logic [SZ_W:0]          blk_log;
  logic [NUM_ROM_WIN-1:0] too_big;

  assign blk_log = (SZ_W+1)'(BLK_LOG_MIN) + (SZ_W+1)'(rom_dens) - (SZ_W+1)'(rom_wide);

  for (genvar w = 0; w < NUM_ROM_WIN; w++) begin : g_size
    assign too_big[w] = win_en[w] && ({1'b0, win_size[w]} > blk_log);
  end

  assign cfg_err = (|pair_bad) || (|too_big) || (rom_dens == DENS_RSVD);

  a_r9_rsvd_density: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_dens == DENS_RSVD) |-> cfg_err);

  a_r8_ram_io_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en[WIN_RAM] && win_en[WIN_IO] && (win_base[WIN_RAM] == win_base[WIN_IO])) |-> cfg_err);

endmodule

// File: rtl/csdec_select_stage.sv
module csdec_select_stage
  import csdec_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cyc_strobe,
  input  logic                   cfg_err,
  input  logic [NUM_WIN-1:0]     hit,
  output logic [NUM_ROM_BLK-1:0] rom_sel,
  output logic                   ram_sel,
  output logic                   io_sel,
  output logic                   pio_sel
);

  logic [NUM_ROM_BLK-1:0] rom_hit;

  for (genvar b = 0; b < NUM_ROM_BLK; b++) begin : g_blk
    if (b == WIN_B7_A) begin : g_dual
      assign rom_hit[b] = hit[WIN_B7_A] | hit[WIN_B7_B];
    end else begin : g_single
      assign rom_hit[b] = hit[b];
    end
  end

  logic [NUM_ROM_BLK-1:0] rom_d, rom_q;
  logic                   ram_d, io_d, pio_d;
  logic                   ram_q, io_q, pio_q;
  logic                   upd;

  always_comb begin
    rom_d = '0;
    ram_d = 1'b0;
    io_d  = 1'b0;
    pio_d = 1'b0;
    if (cyc_strobe && !cfg_err) begin
      if (hit[WIN_RAM])      ram_d = 1'b1;
      else if (hit[WIN_IO])  io_d  = 1'b1;
      else if (hit[WIN_PIO]) pio_d = 1'b1;
      else begin
        for (int b = NUM_ROM_BLK - 1; b >= 0; b--) begin
          if (rom_hit[b]) begin
            rom_d    = '0;
            rom_d[b] = 1'b1;
          end
        end
      end
    end
    // hold the register while idle and already clear
    upd = cyc_strobe || (|rom_q) || ram_q || io_q || pio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_q <= '0;
      ram_q <= 1'b0;
      io_q  <= 1'b0;
      pio_q <= 1'b0;
    end else if (upd) begin
      rom_q <= rom_d;
      ram_q <= ram_d;
      io_q  <= io_d;
      pio_q <= pio_d;
    end
  end

  assign rom_sel = rom_q;
  assign ram_sel = ram_q;
  assign io_sel  = io_q;
  assign pio_sel = pio_q;

  a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pio_q, io_q, ram_q, rom_q}));

  a_r10_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> ({pio_q, io_q, ram_q, rom_q} == '0));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> ({pio_q, io_q, ram_q, rom_q} == '0));

  a_r5_ram_over_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && !cfg_err && hit[WIN_RAM]) |=> (ram_q && (rom_q == '0)));

  a_r4_block7_either: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && !cfg_err && (hit[WIN_B7_A] || hit[WIN_B7_B]) &&
     !hit[WIN_RAM] && !hit[WIN_IO] && !hit[WIN_PIO]) |=> rom_q[WIN_B7_A]);

endmodule

// File: rtl/csdec_map.sv
module csdec_map
  import csdec_pkg::*;
#(
  parameter int  ADDR_W      = 16,
  parameter int  BLK_LOG_MIN = 12,
  localparam int SZ_W        = $clog2(ADDR_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cyc_strobe,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   cfg_we,
  input  logic [CFG_IDX_W-1:0]   cfg_idx,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic [SZ_W-1:0]        cfg_size,
  input  logic                   cfg_en,
  output logic [NUM_ROM_BLK-1:0] rom_sel,
  output logic                   ram_sel,
  output logic                   io_sel,
  output logic                   pio_sel,
  output logic                   config_error
);

  // reset: asserted at once, released on the clock
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [ADDR_W-1:0]  win_base [NUM_WIN];
  logic [SZ_W-1:0]    win_size [NUM_WIN];
  logic               win_en   [NUM_WIN];
  rom_dens_e          rom_dens;
  logic               rom_wide;
  logic [NUM_WIN-1:0] hit;
  logic               cfg_err;

  csdec_cfg_regs #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_base (cfg_base),
    .cfg_size (cfg_size),
    .cfg_en   (cfg_en),
    .win_base (win_base),
    .win_size (win_size),
    .win_en   (win_en),
    .rom_dens (rom_dens),
    .rom_wide (rom_wide)
  );

  csdec_window_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
    .addr     (addr),
    .win_base (win_base),
    .win_size (win_size),
    .win_en   (win_en),
    .hit      (hit)
  );

  csdec_rule_check #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .BLK_LOG_MIN(BLK_LOG_MIN)) u_rules (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .win_base (win_base),
    .win_size (win_size),
    .win_en   (win_en),
    .rom_dens (rom_dens),
    .rom_wide (rom_wide),
    .cfg_err  (cfg_err)
  );

  csdec_select_stage u_sel (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cyc_strobe (cyc_strobe),
    .cfg_err    (cfg_err),
    .hit        (hit),
    .rom_sel    (rom_sel),
    .ram_sel    (ram_sel),
    .io_sel     (io_sel),
    .pio_sel    (pio_sel)
  );

  assign config_error = cfg_err;

endmodule

// File: tb/csdec_map_test.sv
module csdec_map_test;

  logic        clk;
  logic        rst_n;
  logic        cyc_strobe;
  logic [15:0] addr;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_base;
  logic [4:0]  cfg_size;
  logic        cfg_en;
  logic [7:0]  rom_sel;
  logic        ram_sel, io_sel, pio_sel, config_error;

  int checks = 0;
  int fails  = 0;

  // bench model of the configuration
  int mb[12];
  int ms[12];
  bit me[12];
  int dens = 0;
  int wide = 0;

  csdec_map uut (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .addr(addr),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_en(cfg_en), .rom_sel(rom_sel),
    .ram_sel(ram_sel), .io_sel(io_sel), .pio_sel(pio_sel),
    .config_error(config_error)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit in_win(int w, int a);
    if (!me[w]) return 1'b0;
    if (ms[w] >= 16) return 1'b1;
    return (a >> ms[w]) == (mb[w] >> ms[w]);
  endfunction

  function automatic bit overlap(int i, int j);
    int m;
    m = (ms[i] > ms[j]) ? ms[i] : ms[j];
    if (m >= 16) return 1'b1;
    return (mb[i] >> m) == (mb[j] >> m);
  endfunction

  function automatic bit exp_err();
    if (dens == 3) return 1'b1;
    for (int w = 0; w < 9; w++)
      if (me[w] && ms[w] > 12 + dens - wide) return 1'b1;
    for (int i = 0; i < 12; i++)
      for (int j = i + 1; j < 12; j++) begin
        bit rel;
        rel = (i < 9 && j < 9 && (i == 8 ? 7 : i) != (j == 8 ? 7 : j)) ||
              (i >= 9 && j >= 9);
        if (rel && me[i] && me[j] && overlap(i, j)) return 1'b1;
      end
    return 1'b0;
  endfunction

  // {pio, io, ram, rom[7:0]}
  function automatic logic [10:0] exp_sel(int a, bit s);
    logic [10:0] r;
    r = '0;
    if (!s || exp_err()) return r;
    if (in_win(9, a))       r[8]  = 1'b1;
    else if (in_win(10, a)) r[9]  = 1'b1;
    else if (in_win(11, a)) r[10] = 1'b1;
    else begin
      for (int b = 7; b >= 0; b--) begin
        bit h;
        h = in_win(b, a) || (b == 7 && in_win(8, a));
        if (h) begin r = '0; r[b] = 1'b1; end
      end
    end
    return r;
  endfunction

  task automatic wr(input int idx, input int base, input int sz, input bit en);
    cyc_strobe = 1'b0;
    cfg_we   = 1'b1;
    cfg_idx  = 4'(idx);
    cfg_base = 16'(base);
    cfg_size = 5'(sz);
    cfg_en   = en;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 12) begin
      mb[idx] = base; ms[idx] = sz; me[idx] = en;
    end else if (idx == 15) begin
      dens = base & 3; wide = (base >> 2) & 1;
    end
  endtask

  task automatic probe(input int a, input bit s, input string req);
    logic [10:0] e, act;
    addr = 16'(a);
    cyc_strobe = s;
    @(negedge clk);
    e   = exp_sel(a, s);
    act = {pio_sel, io_sel, ram_sel, rom_sel};
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s addr=%h strobe=%0b actual=%b expected=%b", req, a, s, act, e);
    end
  endtask

  task automatic chk_err(input string req);
    checks++;
    if (config_error !== exp_err()) begin
      fails++;
      $display("FAIL %s config_error actual=%0b expected=%0b", req, config_error, exp_err());
    end
  endtask

  task automatic sweep(input int gap);
    for (int k = 0; k < 4096; k++) begin
      probe(k * 16, (k % gap) != 3, "R2/R3/R5/R6 sweep");
      probe(k * 16 + 15, (k % gap) != 3, "R2/R3/R5/R6 sweep");
    end
  endtask

  task automatic legal_map();
    for (int b = 0; b < 7; b++) wr(b, b * 16'h1000, 12, 1'b1);
    wr(7, 16'h7000, 11, 1'b1);   // block 7 window A
    wr(8, 16'hFFF0, 4, 1'b1);    // block 7 window B
    wr(9, 16'h0200, 9, 1'b1);    // SRAM over block 0
    wr(10, 16'h7100, 8, 1'b1);   // I/O over block 7 A
    wr(11, 16'hC000, 10, 1'b1);  // peripheral I/O
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    for (int w = 0; w < 12; w++) begin mb[w] = 0; ms[w] = 0; me[w] = 1'b0; end
    rst_n = 1'b0; cyc_strobe = 1'b0; addr = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_size = '0; cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({pio_sel, io_sel, ram_sel, rom_sel, config_error} !== 12'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b expected=0",
               {pio_sel, io_sel, ram_sel, rom_sel, config_error});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_err("R1");
    probe(16'h0000, 1'b1, "R1 windows disabled");
    probe(16'hFFFF, 1'b1, "R1 windows disabled");

    legal_map();
    chk_err("R7/R8 legal map");
    probe(16'h0200, 1'b1, "R5 sram over rom0");
    probe(16'h01FF, 1'b1, "R2 rom0 below sram");
    probe(16'h7100, 1'b1, "R5 io over block7");
    probe(16'h7000, 1'b1, "R4 window A");
    probe(16'hFFF5, 1'b1, "R4 window B");
    probe(16'hC3FF, 1'b1, "R2 pio top");
    probe(16'h9000, 1'b1, "R2 no window");
    probe(16'h0200, 1'b0, "R3 strobe low");
    sweep(7);

    // R11: unused index has no effect
    wr(12, 16'h0000, 16, 1'b1);
    chk_err("R11 unused index");
    probe(16'h9000, 1'b1, "R11 unused index");
    probe(16'h0200, 1'b1, "R11 unused index");

    // R2: base low bits ignored, disabled window silent
    wr(11, 16'hC005, 10, 1'b1);
    probe(16'hC000, 1'b1, "R2 unaligned base");
    probe(16'hC3FF, 1'b1, "R2 unaligned base");
    probe(16'hC400, 1'b1, "R2 past end");
    wr(11, 16'hC000, 10, 1'b0);
    probe(16'hC000, 1'b1, "R2 disabled");
    wr(11, 16'hC000, 10, 1'b1);

    // R8: RAM and I/O clash
    wr(10, 16'h0200, 8, 1'b1);
    chk_err("R8 io inside sram");
    probe(16'h0200, 1'b1, "R10 error quiet");
    probe(16'h5000, 1'b1, "R10 error quiet");
    wr(10, 16'h7100, 8, 1'b1);
    chk_err("R8 restored");

    // R7: two ROM blocks overlap
    wr(1, 16'h0000, 12, 1'b1);
    chk_err("R7 rom clash");
    probe(16'h0000, 1'b1, "R10 error quiet");
    wr(1, 16'h1000, 12, 1'b1);
    chk_err("R7 restored");

    // R7: block 7 windows may overlap each other
    wr(8, 16'h7000, 4, 1'b1);
    chk_err("R7 block7 self overlap");
    probe(16'h7005, 1'b1, "R4 both windows");
    wr(8, 16'hFFF0, 4, 1'b1);

    // R9: wide organisation halves the block
    wr(15, 4, 0, 1'b0);
    chk_err("R9 wide too small");
    probe(16'h3000, 1'b1, "R10 error quiet");
    wr(15, 0, 0, 1'b0);
    chk_err("R9 restored");
    wr(15, 3, 0, 1'b0);
    chk_err("R9 reserved density");
    wr(15, 0, 0, 1'b0);

    // R9: larger block needs larger density
    wr(0, 16'h8000, 13, 1'b1);
    chk_err("R9 block too large");
    wr(15, 1, 0, 1'b0);
    chk_err("R9 density raised");
    probe(16'h9FFF, 1'b1, "R9 large block");
    sweep(5);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule